// File: doc/BRIEF.md
# Six-Channel Pixel Word Decimator

The block accepts a stream of 12-bit pixel codes on a single parallel bus and distributes consecutive codes over six channel registers, one code per active pixel-clock edge. Each channel has two register stages. A code first lands in the channel's load stage. A transfer request then copies all six load stages into the output stages in one step, so the next line can be collected while the current outputs stay unchanged.

The pixel clock, the strobes and the data are not used as clocks. They are sampled by a faster system clock, at least four times the pixel rate. Rising and falling pixel-clock edges are recovered from the synchronized samples, so the whole block runs on one clock.

Several controls shape the sequencing:
- An edge-select input chooses whether the rising or the falling pixel edge is active.
- A start strobe arms a new sequence for the next edge of the same polarity.
- A direction select chooses whether filling runs from channel 0 upward or from channel 5 downward.
- A transfer request seen on a rising edge takes effect on the following falling edge, together with the polarity flag.
- A standby input freezes the block.

Top module: `pix_decimator`

## Requirements
- R1: Codes are 12-bit straight binary with bit 11 as MSB. Channel c occupies `ch_codes[12c+11:12c]`. A synchronous reset clears every code, `inv_out` and `seq_done`.
- R2: With `edge_sel` high only rising pixel-clock edges load codes. With `edge_sel` low only falling edges do.
- R3: A sequence begins on an active edge only if `seq_start` was high at the previous pixel-clock edge of the same polarity. The code present on that beginning edge goes to the first channel.
- R4: With `load_dir` low the first channel is 0 and filling moves upward. With `load_dir` high it starts at channel 5 and moves downward. The direction is taken at the beginning edge and held for the rest of the sequence.
- R5: Each active edge of a running sequence loads exactly one channel. After the sixth code, further active edges load nothing until a new start condition.
- R6: If `xfer_req` is high at a rising pixel-clock edge, all load stages are copied to the outputs on the next falling edge. At all other times the outputs hold while loading goes on.
- R7: `inv_out` takes the value of `inv_req` at the falling edge on which a transfer happens, and changes at no other time.
- R8: `seq_done` is high for exactly one system clock cycle when the sixth code of a sequence is loaded. An interrupted sequence gives no pulse.
- R9: While `standby` is high, no code is loaded, no transfer occurs, and start or transfer strobes are not recorded. Outputs and sequencing state keep their values.
- R10: A start condition met during a running sequence restarts filling at the first channel.
- R11: When a falling edge both loads a code and performs a transfer, the outputs receive the load-stage contents from before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| pix_data | input | 12 | Pixel code, bit 11 MSB |
| seq_start | input | 1 | Start strobe, arms the next same-polarity edge |
| load_dir | input | 1 | 0: fill from channel 0 up, 1: from channel 5 down |
| edge_sel | input | 1 | 1: rising edge active, 0: falling edge active |
| xfer_req | input | 1 | Transfer request, sampled at rising edges |
| inv_req | input | 1 | Polarity flag, captured with a transfer |
| standby | input | 1 | Freezes loading, transfers and strobe history |
| ch_codes | output | 72 | Six output-stage codes, channel c at bits 12c+11..12c |
| inv_out | output | 1 | Polarity flag matching the present output codes |
| seq_done | output | 1 | One-cycle pulse when the sixth code is loaded |

## Verification
A wrong channel pointer or latched direction is invisible until the next transfer. After that transfer it shows as codes sitting in permuted or duplicated channel slots, so every scenario ends with a transfer and a full six-channel comparison.

A stale start-history flag shows either as a sequence that never begins or as a spurious overwrite. The second case is exposed one transfer later, when outputs that should be unchanged differ. A wrong sequence counter shows on `seq_done` within a cycle of the sixth load, as a missing or repeated pulse.

Standby leaks are caught by leaving standby and transferring at once. The load stage then has to still hold the code it held before standby.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;

   // index of the channel a sequence begins on
   function automatic int first_channel(input dir_e d, input int n_ch);
      return (d == DIR_DOWN) ? (n_ch - 1) : 0;
   endfunction

endpackage

// File: rtl/pxd_sampler.sv
module pxd_sampler
   import pxd_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_clk,
   input  logic [DATA_W-1:0] pix_data,
   input  logic              start,
   input  logic              dir,
   input  logic              edge_sel,
   input  logic              xfer,
   input  logic              inv,
   input  logic              stby,
   output logic [DATA_W-1:0] data_s,
   output logic              start_s,
   output logic              dir_s,
   output logic              edge_s,
   output logic              xfer_s,
   output logic              inv_s,
   output logic              stby_s,
   output logic              rise,
   output logic              fall
);

   localparam int B_PCLK  = DATA_W;
   localparam int B_START = DATA_W + 1;
   localparam int B_DIR   = DATA_W + 2;
   localparam int B_EDGE  = DATA_W + 3;
   localparam int B_XFER  = DATA_W + 4;
   localparam int B_INV   = DATA_W + 5;
   localparam int B_STBY  = DATA_W + 6;
   localparam int VW      = DATA_W + 7;

   logic [VW-1:0] raw;
   logic [VW-1:0] stg [SYNC_STAGES];
   logic [VW-1:0] tail;
   logic          pclk_q;

   assign raw = {stby, inv, xfer, edge_sel, dir, start, pix_clk, pix_data};

   // every input travels through the same chain so all stay aligned
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
         pclk_q <= 1'b0;
      end else begin
         stg[0] <= raw;
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         pclk_q <= stg[SYNC_STAGES-1][B_PCLK];
      end
   end

   assign tail    = stg[SYNC_STAGES-1];
   assign data_s  = tail[DATA_W-1:0];
   assign start_s = tail[B_START];
   assign dir_s   = tail[B_DIR];
   assign edge_s  = tail[B_EDGE];
   assign xfer_s  = tail[B_XFER];
   assign inv_s   = tail[B_INV];
   assign stby_s  = tail[B_STBY];
   assign rise    = tail[B_PCLK] & ~pclk_q;
   assign fall    = ~tail[B_PCLK] & pclk_q;

   // R2: an edge pulse lasts one cycle, since the history register follows the sample
   a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
   a_r2_fall_single: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall);

endmodule

// File: rtl/pxd_ctrl.sv
module pxd_ctrl
   import pxd_pkg::*;
#(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rise,
   input  logic              fall,
   input  logic              edge_s,
   input  logic              start_s,
   input  logic              dir_s,
   input  logic              stby_s,
   output logic [NUM_CH-1:0] ld_en,
   output logic              done
);

   localparam int             IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int             CW    = $clog2(NUM_CH + 1);
   localparam logic [CW-1:0]  FULL  = CW'(NUM_CH);
   localparam logic [IW-1:0]  IDX_U = IW'(first_channel(DIR_UP, NUM_CH));
   localparam logic [IW-1:0]  IDX_D = IW'(first_channel(DIR_DOWN, NUM_CH));

   logic          hist_r, hist_f;
   logic          busy;
   dir_e          dir_q, cur_dir;
   logic [IW-1:0] ptr, cur_idx;
   logic [CW-1:0] cnt, cnt_nxt;
   logic          act, begin_seq, step, ld_any;

   always_comb begin
      act       = !stby_s && (edge_s ? rise : fall);
      begin_seq = act && (edge_s ? hist_r : hist_f);
      step      = act && busy && !begin_seq;
      ld_any    = begin_seq || step;
      cur_dir   = begin_seq ? dir_e'(dir_s) : dir_q;
      if (begin_seq) cur_idx = (dir_e'(dir_s) == DIR_DOWN) ? IDX_D : IDX_U;
      else           cur_idx = ptr;
      cnt_nxt   = begin_seq ? CW'(1) : (cnt + CW'(1));
      ld_en     = ld_any ? (NUM_CH'(1) << cur_idx) : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_r <= 1'b0;
         hist_f <= 1'b0;
         busy   <= 1'b0;
         dir_q  <= DIR_UP;
         ptr    <= '0;
         cnt    <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!stby_s) begin
            if (rise) hist_r <= start_s;
            if (fall) hist_f <= start_s;
         end
         if (ld_any) begin
            dir_q <= cur_dir;
            ptr   <= (cur_dir == DIR_DOWN) ? (cur_idx - IW'(1)) : (cur_idx + IW'(1));
            cnt   <= cnt_nxt;
            busy  <= (cnt_nxt != FULL);
            done  <= (cnt_nxt == FULL);
         end
      end
   end

   // R5: the counter of loaded codes never passes the channel count
   a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
      cnt <= FULL);
   // R5: at most one channel takes a code per cycle
   a_r5_single_load: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ld_en));
   // R8: completion pulse is one cycle wide
   a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R9: strobe history is frozen in standby
   a_r9_hist_frozen: assert property (@(posedge clk) disable iff (rst)
      stby_s |=> ($stable(hist_r) && $stable(hist_f)));

endmodule

// File: rtl/pxd_xfer.sv
module pxd_xfer (
   input  logic clk,
   input  logic rst,
   input  logic rise,
   input  logic fall,
   input  logic xfer_s,
   input  logic inv_s,
   input  logic stby_s,
   output logic fire,
   output logic inv_o
);

   logic pend;

   assign fire = fall && pend && !stby_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend  <= 1'b0;
         inv_o <= 1'b0;
      end else if (!stby_s) begin
         if (rise && xfer_s) pend <= 1'b1;
         else if (fall)      pend <= 1'b0;
         if (fire)           inv_o <= inv_s;
      end
   end

   // R6: a pending request is consumed by the falling edge that follows it
   a_r6_pend_consumed: assert property (@(posedge clk) disable iff (rst)
      fire |=> !pend);

endmodule

// File: rtl/pxd_chan.sv
module pxd_chan #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic              xfer,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] hold_q;

   // on a simultaneous load and transfer the output takes the older code
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         q      <= '0;
      end else begin
         if (ld)   hold_q <= din;
         if (xfer) q      <= hold_q;
      end
   end

endmodule

// File: rtl/pix_decimator.sv
module pix_decimator
   import pxd_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int NUM_CH      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     pix_clk,
   input  logic [DATA_W-1:0]        pix_data,
   input  logic                     seq_start,
   input  logic                     load_dir,
   input  logic                     edge_sel,
   input  logic                     xfer_req,
   input  logic                     inv_req,
   input  logic                     standby,
   output logic [NUM_CH*DATA_W-1:0] ch_codes,
   output logic                     inv_out,
   output logic                     seq_done
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pix_decimator: DATA_W must be at least 1");
      end
      if (NUM_CH < 2) begin : g_bad_channels
         $error("pix_decimator: NUM_CH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pix_decimator: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] data_s;
   logic              start_s, dir_s, edge_s, xfer_s, inv_s, stby_s;
   logic              rise, fall;
   logic [NUM_CH-1:0] ld_en;
   logic              fire;

   pxd_sampler #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk      (clk),
      .rst      (rst),
      .pix_clk  (pix_clk),
      .pix_data (pix_data),
      .start    (seq_start),
      .dir      (load_dir),
      .edge_sel (edge_sel),
      .xfer     (xfer_req),
      .inv      (inv_req),
      .stby     (standby),
      .data_s   (data_s),
      .start_s  (start_s),
      .dir_s    (dir_s),
      .edge_s   (edge_s),
      .xfer_s   (xfer_s),
      .inv_s    (inv_s),
      .stby_s   (stby_s),
      .rise     (rise),
      .fall     (fall)
   );

   pxd_ctrl #(
      .NUM_CH (NUM_CH)
   ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .rise    (rise),
      .fall    (fall),
      .edge_s  (edge_s),
      .start_s (start_s),
      .dir_s   (dir_s),
      .stby_s  (stby_s),
      .ld_en   (ld_en),
      .done    (seq_done)
   );

   pxd_xfer u_xfer (
      .clk    (clk),
      .rst    (rst),
      .rise   (rise),
      .fall   (fall),
      .xfer_s (xfer_s),
      .inv_s  (inv_s),
      .stby_s (stby_s),
      .fire   (fire),
      .inv_o  (inv_out)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         pxd_chan #(
            .DATA_W (DATA_W)
         ) u_chan (
            .clk  (clk),
            .rst  (rst),
            .ld   (ld_en[c]),
            .xfer (fire),
            .din  (data_s),
            .q    (ch_codes[c*DATA_W +: DATA_W])
         );
      end
   endgenerate

   // R6: outputs move only right after a falling pixel edge
   a_r6_out_after_fall: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_codes) |-> $past(fall));
   // R7: polarity moves only right after a falling pixel edge
   a_r7_inv_after_fall: assert property (@(posedge clk) disable iff (rst)
      !$stable(inv_out) |-> $past(fall));
   // R9: standby freezes the outputs
   a_r9_standby_freeze: assert property (@(posedge clk) disable iff (rst)
      stby_s |=> ($stable(ch_codes) && $stable(inv_out)));
   // R8: completion follows a pixel edge
   a_r8_done_after_edge: assert property (@(posedge clk) disable iff (rst)
      seq_done |-> $past(rise || fall));

endmodule

// File: tb/pix_decimator_tb.sv
`timescale 1ns/1ps
module pix_decimator_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pix_clk = 1'b0;
   logic [11:0] pix_data = '0;
   logic        seq_start = 1'b0;
   logic        load_dir = 1'b0;
   logic        edge_sel = 1'b1;
   logic        xfer_req = 1'b0;
   logic        inv_req = 1'b0;
   logic        standby = 1'b0;
   logic [71:0] ch_codes;
   logic        inv_out;
   logic        seq_done;

   int          n_tests = 0;
   int          n_fail = 0;
   int          done_cnt = 0;
   bit          finished = 1'b0;
   logic [11:0] exp_c [6];

   always #2.5 clk = ~clk;

   pix_decimator u_dut (
      .clk       (clk),
      .rst       (rst),
      .pix_clk   (pix_clk),
      .pix_data  (pix_data),
      .seq_start (seq_start),
      .load_dir  (load_dir),
      .edge_sel  (edge_sel),
      .xfer_req  (xfer_req),
      .inv_req   (inv_req),
      .standby   (standby),
      .ch_codes  (ch_codes),
      .inv_out   (inv_out),
      .seq_done  (seq_done)
   );

   always @(posedge clk) begin
      if (rst) done_cnt <= 0;
      else if (seq_done) done_cnt <= done_cnt + 1;
   end

   function automatic logic [11:0] word(input logic [11:0] base, input int i);
      return base + 12'(i * 12'h111);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // set inputs, let them settle, move the pixel clock, let it propagate
   task automatic drive(input logic lvl, input logic [11:0] d, input logic st,
                        input logic xf, input logic iv);
      pix_data  = d;
      seq_start = st;
      xfer_req  = xf;
      inv_req   = iv;
      tick(2);
      pix_clk = lvl;
      tick(5);
   endtask

   task automatic check1(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_codes(input string req);
      for (int c = 0; c < 6; c++)
         check1(req, 32'(ch_codes[c*12 +: 12]), 32'(exp_c[c]));
   endtask

   task automatic do_xfer(input logic iv);
      drive(1'b1, 12'hFFF, 1'b0, 1'b1, iv);
      drive(1'b0, 12'hFFF, 1'b0, 1'b0, iv);
   endtask

   // R1: reset state
   task automatic t_reset();
      check1("R1 reset codes", 32'(ch_codes == '0), 32'd1);
      check1("R1 reset inv", 32'(inv_out), 32'd0);
      check1("R1 reset done", 32'(seq_done), 32'd0);
   endtask

   // R2 R3 R4 R5 R6 R7 R8: rising mode, upward
   task automatic t_rise_up();
      edge_sel = 1'b1; load_dir = 1'b0; tick(3);
      drive(1'b1, 12'h000, 1'b1, 1'b0, 1'b0);
      drive(1'b0, 12'hEEE, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) begin
         drive(1'b1, word(12'h123, i), 1'b0, 1'b0, 1'b0);
         drive(1'b0, 12'hEEE, 1'b0, 1'b0, 1'b0);
      end
      for (int c = 0; c < 6; c++) exp_c[c] = 12'h000;
      check_codes("R6 outputs hold before transfer");
      check1("R8 done pulse count", 32'(done_cnt), 32'd1);
      do_xfer(1'b1);
      for (int c = 0; c < 6; c++) exp_c[c] = word(12'h123, c);
      check_codes("R2 R3 R4 R5 rising upward fill");
      check1("R7 inv captured high", 32'(inv_out), 32'd1);
      check1("R8 no extra done", 32'(done_cnt), 32'd1);
   endtask

   // R2 R4: falling mode, downward, direction change mid-sequence ignored
   task automatic t_fall_down();
      edge_sel = 1'b0; load_dir = 1'b1; tick(3);
      drive(1'b1, 12'h000, 1'b0, 1'b0, 1'b1);
      drive(1'b0, 12'h000, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 6; i++) begin
         drive(1'b1, 12'hDDD, 1'b0, 1'b0, 1'b1);
         drive(1'b0, word(12'h456, i), 1'b0, 1'b0, 1'b1);
         if (i == 0) load_dir = 1'b0;
      end
      check1("R7 inv unchanged without transfer", 32'(inv_out), 32'd1);
      do_xfer(1'b0);
      for (int c = 0; c < 6; c++) exp_c[c] = word(12'h456, 5 - c);
      check_codes("R2 R4 falling downward fill");
      check1("R7 inv captured low", 32'(inv_out), 32'd0);
      check1("R8 done count", 32'(done_cnt), 32'd2);
   endtask

   // R10: restart mid-sequence
   task automatic t_restart();
      load_dir = 1'b0; tick(3);
      drive(1'b1, 12'h000, 1'b0, 1'b0, 1'b0);
      drive(1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) begin
         drive(1'b1, 12'h000, 1'b0, 1'b0, 1'b0);
         drive(1'b0, word(12'h700, i), (i == 2), 1'b0, 1'b0);
      end
      check1("R8 no done on partial", 32'(done_cnt), 32'd2);
      for (int i = 0; i < 6; i++) begin
         drive(1'b1, 12'h000, 1'b0, 1'b0, 1'b0);
         drive(1'b0, word(12'h8A1, i), 1'b0, 1'b0, 1'b0);
      end
      do_xfer(1'b0);
      for (int c = 0; c < 6; c++) exp_c[c] = word(12'h8A1, c);
      check_codes("R10 restart at first channel");
      check1("R8 done after restart", 32'(done_cnt), 32'd3);
   endtask

   // R11: load and transfer on one falling edge
   task automatic t_same_edge();
      drive(1'b1, 12'h000, 1'b0, 1'b0, 1'b0);
      drive(1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) begin
         drive(1'b1, 12'h000, 1'b0, 1'b0, 1'b0);
         drive(1'b0, word(12'h0F5, i), 1'b0, 1'b0, 1'b0);
      end
      drive(1'b1, 12'h000, 1'b0, 1'b1, 1'b0);
      drive(1'b0, word(12'h0F5, 5), 1'b0, 1'b0, 1'b0);
      for (int c = 0; c < 5; c++) exp_c[c] = word(12'h0F5, c);
      exp_c[5] = word(12'h8A1, 5);
      check_codes("R11 transfer takes older load stage");
      do_xfer(1'b0);
      exp_c[5] = word(12'h0F5, 5);
      check_codes("R11 later transfer takes new code");
   endtask

   // R9: standby freezes everything
   task automatic t_standby();
      edge_sel = 1'b1; standby = 1'b1; tick(3);
      drive(1'b1, 12'h000, 1'b1, 1'b0, 1'b1);
      drive(1'b0, 12'h000, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 6; i++) begin
         drive(1'b1, word(12'hC3C, i), 1'b0, 1'b1, 1'b1);
         drive(1'b0, word(12'hC3C, i), 1'b0, 1'b0, 1'b1);
      end
      check_codes("R9 outputs frozen in standby");
      check1("R9 inv frozen", 32'(inv_out), 32'd0);
      check1("R9 no done in standby", 32'(done_cnt), 32'd4);
      standby = 1'b0; tick(3);
      drive(1'b1, 12'hC3C, 1'b0, 1'b1, 1'b0);
      drive(1'b0, 12'hC3C, 1'b0, 1'b0, 1'b0);
      check_codes("R9 load stage untouched by standby");
      check1("R9 done unchanged", 32'(done_cnt), 32'd4);
   endtask

   initial begin
      tick(4);
      rst = 1'b0;
      tick(2);
      t_reset();
      t_rise_up();
      t_fall_down();
      t_restart();
      t_same_edge();
      t_standby();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      end
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      end
      $finish;
   end

endmodule